// File: doc/BRIEF.md
# Two-Array TLB Write and Search Unit

This block is a second-level translation lookaside buffer built from two arrays. One is a small fully associative array. The other is a larger two-way set-associative array, indexed by the low bits of the effective page number. Software fills a bank of staging registers through a load port. The staging registers hold the array select, the entry or way select, the valid and address-space bits, the process ID, the effective page number, the attributes, the real page number and a 4-bit real page number extension. A write strobe then commits the staged entry into the one location those fields name.

A search strobe forms an effective address as the sum of two 64-bit operands. It matches that address against both arrays, using the address-space bit and process ID held in a separate search-control staging pair. The result is reloaded into the staging registers, and a hit loads different fields than a miss.

Every search hit is recorded in a small first-level shadow table. Each shadow slot holds a back-pointer to the second-level location it came from. When a write overwrites a valid entry, every shadow slot pointing at that victim is invalidated in the same cycle.

Top module: `tlb2_unit`

## Requirements
- R1: A write with array select 01 stores the staged entry into fully associative entry number `esel`. A later matching search reports array select 01 and that entry number.
- R2: A write with array select 00 stores the staged entry into way `esel[0]` of set `epn[6:0]`. Both ways of one set can hold different pages at the same time, and each is found by search.
- R3: The 4-bit real page number extension is stored by a write and returned by a search hit on that entry.
- R4: A write changes only the one addressed entry. Entries written earlier remain found, with their stored contents.
- R5: When a write overwrites a valid entry, every shadow slot whose back-pointer names that location is cleared in the same cycle. A write to an empty location leaves the shadow valid bits unchanged, even if a slot shares its way or entry number in another set.
- R6: The search address is `opa_i + opb_i` modulo 2^64. The effective page number is bits 63:12 of that sum.
- R7: A search hits an entry only when the entry is valid and its address-space bit, process ID and page number all equal the search values. On a hit the staging registers receive the entry's fields and its location, with `esel` set to the entry number (fully associative) or to the zero-extended way number (set-associative).
- R8: On a search miss, staging valid becomes 0. The staging address-space bit and process ID take the search-control values, and the staging page number takes the search page number. Array select, entry select, attributes and real page fields keep their values.
- R9: If both arrays hit, the fully associative result is reported.
- R10: A write whose array select is 10 or 11 changes no array entry and no shadow bit.
- R11: `done_o` is high for exactly the one cycle after each write or search strobe, and search results are in the staging outputs in that cycle. A write and a search in the same cycle perform only the write. A staging load in the same cycle as a command is dropped.
- R12: Each search hit fills the next shadow slot in round-robin order 0,1,2,3,0. Search misses and writes fill no slot.
- R13: After reset, all staging fields are 0, `done_o` is 0, no shadow slot is valid, and no array entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Load entry staging fields from the ld_* inputs |
| ld_tsel_i | input | 2 | Array select to stage (00 set-assoc, 01 fully assoc) |
| ld_esel_i | input | 4 | Entry number or way to stage |
| ld_valid_i | input | 1 | Valid bit to stage |
| ld_ts_i | input | 1 | Address-space bit to stage |
| ld_tid_i | input | 8 | Process ID to stage |
| ld_epn_i | input | 52 | Effective page number to stage |
| ld_attr_i | input | 6 | Attributes to stage |
| ld_rpn_i | input | 24 | Real page number to stage |
| ld_rpnx_i | input | 4 | Real page number extension to stage |
| ld_sc_i | input | 1 | Load the search-control pair |
| ld_sas_i | input | 1 | Search address-space bit |
| ld_spid_i | input | 8 | Search process ID |
| wr_i | input | 1 | Write strobe |
| srch_i | input | 1 | Search strobe |
| opa_i | input | 64 | Search address operand A |
| opb_i | input | 64 | Search address operand B |
| done_o | output | 1 | Command completed |
| stg_tsel_o | output | 2 | Staged array select |
| stg_esel_o | output | 4 | Staged entry or way |
| stg_valid_o | output | 1 | Staged valid bit |
| stg_ts_o | output | 1 | Staged address-space bit |
| stg_tid_o | output | 8 | Staged process ID |
| stg_epn_o | output | 52 | Staged effective page number |
| stg_attr_o | output | 6 | Staged attributes |
| stg_rpn_o | output | 24 | Staged real page number |
| stg_rpnx_o | output | 4 | Staged real page extension |
| l1_valid_o | output | 4 | Valid bit of each shadow slot |

## Verification
The bench builds the unit with its default parameters: 16 fully associative entries, 128 sets of 2 ways, and 4 shadow slots. Sixteen entries make the top entry number 15 reachable. Two ways per set allow two pages that collide on set 1 to sit side by side. Four slots let the round-robin pointer wrap within a handful of hits, so a victim write can be shown to clear only the slots pointing at it. A set-2 write into the same way number as a live set-1 entry separates the set compare from the way compare in the back-pointer match.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
    localparam int VA_W   = 64;
    localparam int PG_SH  = 12;
    localparam int EPN_W  = VA_W - PG_SH;
    localparam int PID_W  = 8;
    localparam int RPN_W  = 24;
    localparam int RPNX_W = 4;
    localparam int ATTR_W = 6;
    localparam int ESEL_W = 4;
    localparam int SET_W  = 7;

    localparam logic [1:0] SEL_SA = 2'b00;
    localparam logic [1:0] SEL_FA = 2'b01;

    typedef struct packed {
        logic               valid;
        logic               ts;
        logic [PID_W-1:0]   tid;
        logic [EPN_W-1:0]   epn;
        logic [ATTR_W-1:0]  attr;
        logic [RPN_W-1:0]   rpn;
        logic [RPNX_W-1:0]  rpnx;
    } tlb_ent_t;

    // Location of a second-level entry: array, set, way or entry number
    typedef struct packed {
        logic               fa;
        logic [SET_W-1:0]   set;
        logic [ESEL_W-1:0]  slot;
    } bptr_t;

    typedef struct packed {
        logic [1:0]         tsel;
        logic [ESEL_W-1:0]  esel;
        tlb_ent_t           ent;
        logic               sas;
        logic [PID_W-1:0]   spid;
    } stg_t;
endpackage

// File: rtl/tlb2_fa.sv
module tlb2_fa
    import tlb2_pkg::*;
#(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IW-1:0]     widx_i,
    input  tlb_ent_t          wdat_i,
    input  logic              s_ts_i,
    input  logic [PID_W-1:0]  s_tid_i,
    input  logic [EPN_W-1:0]  s_epn_i,
    output logic              hit_o,
    output logic [IW-1:0]     hidx_o,
    output tlb_ent_t          hent_o,
    output logic              wvic_o
);
    typedef struct packed {
        tlb_ent_t [N-1:0] ent;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.ent[widx_i] = wdat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Lowest matching entry number wins
    always_comb begin
        hit_o  = 1'b0;
        hidx_o = '0;
        hent_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (st_q.ent[i].valid && st_q.ent[i].ts == s_ts_i &&
                st_q.ent[i].tid == s_tid_i && st_q.ent[i].epn == s_epn_i) begin
                hit_o  = 1'b1;
                hidx_o = IW'(i);
                hent_o = st_q.ent[i];
            end
        end
    end

    assign wvic_o = st_q.ent[widx_i].valid;
endmodule

// File: rtl/tlb2_sa.sv
module tlb2_sa
    import tlb2_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 2,
    localparam int SW = $clog2(SETS),
    localparam int WW = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SW-1:0]     wset_i,
    input  logic [WW-1:0]     wway_i,
    input  tlb_ent_t          wdat_i,
    input  logic [SW-1:0]     sset_i,
    input  logic              s_ts_i,
    input  logic [PID_W-1:0]  s_tid_i,
    input  logic [EPN_W-1:0]  s_epn_i,
    output logic              hit_o,
    output logic [WW-1:0]     hway_o,
    output tlb_ent_t          hent_o,
    output logic              wvic_o
);
    tlb_ent_t [WAYS-1:0] mem_q [SETS];
    tlb_ent_t [WAYS-1:0] mem_d [SETS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[wset_i][wway_i] = wdat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    // Lowest matching way wins
    always_comb begin
        hit_o  = 1'b0;
        hway_o = '0;
        hent_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (mem_q[sset_i][w].valid && mem_q[sset_i][w].ts == s_ts_i &&
                mem_q[sset_i][w].tid == s_tid_i && mem_q[sset_i][w].epn == s_epn_i) begin
                hit_o  = 1'b1;
                hway_o = WW'(w);
                hent_o = mem_q[sset_i][w];
            end
        end
    end

    assign wvic_o = mem_q[wset_i][wway_i].valid;
endmodule

// File: rtl/tlb2_l1.sv
module tlb2_l1
    import tlb2_pkg::*;
#(
    parameter int N = 4,
    localparam int PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_i,
    input  bptr_t         fptr_i,
    input  logic          inv_i,
    input  bptr_t         iptr_i,
    output logic [N-1:0]  vld_o
);
    typedef struct packed {
        logic [N-1:0]  vld;
        bptr_t [N-1:0] ptr;
        logic [PW-1:0] rr;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (inv_i) begin
            for (int i = 0; i < N; i++) begin
                if (st_q.vld[i] && st_q.ptr[i] == iptr_i) st_d.vld[i] = 1'b0;
            end
        end
        if (fill_i) begin
            st_d.vld[st_q.rr] = 1'b1;
            st_d.ptr[st_q.rr] = fptr_i;
            st_d.rr = (st_q.rr == PW'(N - 1)) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
endmodule

// File: rtl/tlb2_unit.sv
module tlb2_unit
    import tlb2_pkg::*;
#(
    parameter int FA_N    = 16,
    parameter int SA_SETS = 128,
    parameter int SA_WAYS = 2,
    parameter int L1_N    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_i,
    input  logic [1:0]         ld_tsel_i,
    input  logic [ESEL_W-1:0]  ld_esel_i,
    input  logic               ld_valid_i,
    input  logic               ld_ts_i,
    input  logic [PID_W-1:0]   ld_tid_i,
    input  logic [EPN_W-1:0]   ld_epn_i,
    input  logic [ATTR_W-1:0]  ld_attr_i,
    input  logic [RPN_W-1:0]   ld_rpn_i,
    input  logic [RPNX_W-1:0]  ld_rpnx_i,
    input  logic               ld_sc_i,
    input  logic               ld_sas_i,
    input  logic [PID_W-1:0]   ld_spid_i,
    input  logic               wr_i,
    input  logic               srch_i,
    input  logic [VA_W-1:0]    opa_i,
    input  logic [VA_W-1:0]    opb_i,
    output logic               done_o,
    output logic [1:0]         stg_tsel_o,
    output logic [ESEL_W-1:0]  stg_esel_o,
    output logic               stg_valid_o,
    output logic               stg_ts_o,
    output logic [PID_W-1:0]   stg_tid_o,
    output logic [EPN_W-1:0]   stg_epn_o,
    output logic [ATTR_W-1:0]  stg_attr_o,
    output logic [RPN_W-1:0]   stg_rpn_o,
    output logic [RPNX_W-1:0]  stg_rpnx_o,
    output logic [L1_N-1:0]    l1_valid_o
);
    localparam int FA_IW = $clog2(FA_N);
    localparam int SA_SW = $clog2(SA_SETS);
    localparam int SA_WW = $clog2(SA_WAYS);

    typedef struct packed {
        stg_t stg;
        logic done;
    } st_t;

    st_t st_q, st_d;

    logic [VA_W-1:0]  saddr;
    logic [EPN_W-1:0] sepn;
    logic [SA_SW-1:0] sset, wset;
    logic [SA_WW-1:0] wway, sa_hway;
    logic [FA_IW-1:0] widx, fa_hidx;
    logic             fa_we, sa_we, fa_hit, sa_hit, fa_wvic, sa_wvic;
    logic             do_srch, fill, inv;
    tlb_ent_t         fa_hent, sa_hent;
    bptr_t            fptr, iptr;

    assign saddr   = opa_i + opb_i;
    assign sepn    = EPN_W'(saddr >> PG_SH);
    assign sset    = sepn[SA_SW-1:0];
    assign wset    = st_q.stg.ent.epn[SA_SW-1:0];
    assign wway    = st_q.stg.esel[SA_WW-1:0];
    assign widx    = st_q.stg.esel[FA_IW-1:0];
    assign fa_we   = wr_i && (st_q.stg.tsel == SEL_FA);
    assign sa_we   = wr_i && (st_q.stg.tsel == SEL_SA);
    assign do_srch = srch_i && !wr_i;
    assign fill    = do_srch && (fa_hit || sa_hit);
    assign inv     = (fa_we && fa_wvic) || (sa_we && sa_wvic);

    always_comb begin
        iptr.fa   = fa_we;
        iptr.set  = fa_we ? '0 : SET_W'(wset);
        iptr.slot = fa_we ? ESEL_W'(widx) : ESEL_W'(wway);
        fptr.fa   = fa_hit;
        fptr.set  = fa_hit ? '0 : SET_W'(sset);
        fptr.slot = fa_hit ? ESEL_W'(fa_hidx) : ESEL_W'(sa_hway);
    end

    tlb2_fa #(.N(FA_N)) u_fa (
        .clk(clk), .rst_n(rst_n), .we_i(fa_we), .widx_i(widx),
        .wdat_i(st_q.stg.ent), .s_ts_i(st_q.stg.sas), .s_tid_i(st_q.stg.spid),
        .s_epn_i(sepn), .hit_o(fa_hit), .hidx_o(fa_hidx), .hent_o(fa_hent),
        .wvic_o(fa_wvic)
    );

    tlb2_sa #(.SETS(SA_SETS), .WAYS(SA_WAYS)) u_sa (
        .clk(clk), .rst_n(rst_n), .we_i(sa_we), .wset_i(wset), .wway_i(wway),
        .wdat_i(st_q.stg.ent), .sset_i(sset), .s_ts_i(st_q.stg.sas),
        .s_tid_i(st_q.stg.spid), .s_epn_i(sepn), .hit_o(sa_hit),
        .hway_o(sa_hway), .hent_o(sa_hent), .wvic_o(sa_wvic)
    );

    tlb2_l1 #(.N(L1_N)) u_l1 (
        .clk(clk), .rst_n(rst_n), .fill_i(fill), .fptr_i(fptr),
        .inv_i(inv), .iptr_i(iptr), .vld_o(l1_valid_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = wr_i || srch_i;
        if (do_srch) begin
            if (fa_hit) begin
                st_d.stg.tsel = SEL_FA;
                st_d.stg.esel = ESEL_W'(fa_hidx);
                st_d.stg.ent  = fa_hent;
            end else if (sa_hit) begin
                st_d.stg.tsel = SEL_SA;
                st_d.stg.esel = ESEL_W'(sa_hway);
                st_d.stg.ent  = sa_hent;
            end else begin
                st_d.stg.ent.valid = 1'b0;
                st_d.stg.ent.ts    = st_q.stg.sas;
                st_d.stg.ent.tid   = st_q.stg.spid;
                st_d.stg.ent.epn   = sepn;
            end
        end else if (!wr_i) begin
            if (ld_i) begin
                st_d.stg.tsel = ld_tsel_i;
                st_d.stg.esel = ld_esel_i;
                st_d.stg.ent  = '{valid: ld_valid_i, ts: ld_ts_i, tid: ld_tid_i,
                                  epn: ld_epn_i, attr: ld_attr_i, rpn: ld_rpn_i,
                                  rpnx: ld_rpnx_i};
            end
            if (ld_sc_i) begin
                st_d.stg.sas  = ld_sas_i;
                st_d.stg.spid = ld_spid_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o      = st_q.done;
    assign stg_tsel_o  = st_q.stg.tsel;
    assign stg_esel_o  = st_q.stg.esel;
    assign stg_valid_o = st_q.stg.ent.valid;
    assign stg_ts_o    = st_q.stg.ent.ts;
    assign stg_tid_o   = st_q.stg.ent.tid;
    assign stg_epn_o   = st_q.stg.ent.epn;
    assign stg_attr_o  = st_q.stg.ent.attr;
    assign stg_rpn_o   = st_q.stg.ent.rpn;
    assign stg_rpnx_o  = st_q.stg.ent.rpnx;
endmodule

// File: rtl/tlb2_unit_chk.sv
module tlb2_unit_chk
    import tlb2_pkg::*;
#(
    parameter int L1_N = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_i,
    input logic             srch_i,
    input logic             done_o,
    input logic             stg_valid_o,
    input logic             sel_hi,
    input logic [EPN_W-1:0] stg_epn_o,
    input logic [VA_W-1:0]  opa_i,
    input logic [VA_W-1:0]  opb_i,
    input logic [L1_N-1:0]  l1_valid_o
);
    logic [VA_W-1:0]  sum;
    logic [EPN_W-1:0] sum_epn;
    assign sum     = opa_i + opb_i;
    assign sum_epn = EPN_W'(sum >> PG_SH);

    // R11
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i || srch_i) |=> done_o);

    // R11
    done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_i || srch_i));

    // R8
    miss_epn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_i && !wr_i) |=> (stg_valid_o || stg_epn_o == $past(sum_epn)));

    // R12
    l1_one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(l1_valid_o) <= $countones($past(l1_valid_o)) + 1);

    // R5
    wr_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((l1_valid_o & ~$past(l1_valid_o)) == '0));

    // R10
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_hi) |=> $stable(l1_valid_o));
endmodule

bind tlb2_unit tlb2_unit_chk #(.L1_N(L1_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .srch_i(srch_i), .done_o(done_o),
    .stg_valid_o(stg_valid_o), .sel_hi(stg_tsel_o[1]), .stg_epn_o(stg_epn_o),
    .opa_i(opa_i), .opb_i(opb_i), .l1_valid_o(l1_valid_o)
);

// File: tb/tb_tlb2_unit.sv
`timescale 1ns/1ps
module tb_tlb2_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_i = 0, ld_valid_i = 0, ld_ts_i = 0, ld_sc_i = 0, ld_sas_i = 0;
    logic [1:0]  ld_tsel_i = 0;
    logic [3:0]  ld_esel_i = 0, ld_rpnx_i = 0;
    logic [7:0]  ld_tid_i = 0, ld_spid_i = 0;
    logic [51:0] ld_epn_i = 0;
    logic [5:0]  ld_attr_i = 0;
    logic [23:0] ld_rpn_i = 0;
    logic        wr_i = 0, srch_i = 0;
    logic [63:0] opa_i = 0, opb_i = 0;
    logic        done_o, stg_valid_o, stg_ts_o;
    logic [1:0]  stg_tsel_o;
    logic [3:0]  stg_esel_o, stg_rpnx_o, l1_valid_o;
    logic [7:0]  stg_tid_o;
    logic [51:0] stg_epn_o;
    logic [5:0]  stg_attr_o;
    logic [23:0] stg_rpn_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tlb2_unit dut (.*);

    typedef struct packed {
        logic [1:0]  tsel;
        logic [3:0]  esel;
        logic [51:0] epn;
        logic [23:0] rpn;
        logic [3:0]  rpnx;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'b01, 4'd3,  52'h12345, 24'hABCDE, 4'h3},
        '{2'b01, 4'd15, 52'h00777, 24'h13579, 4'hA},
        '{2'b00, 4'd0,  52'h00481, 24'h02468, 4'h5},
        '{2'b00, 4'd1,  52'h00501, 24'hFEDCB, 4'hC}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] tsel, input logic [3:0] esel,
                        input logic [51:0] epn, input logic [23:0] rpn,
                        input logic [3:0] rpnx);
        @(negedge clk);
        ld_i = 1; ld_tsel_i = tsel; ld_esel_i = esel; ld_valid_i = 1; ld_ts_i = 0;
        ld_tid_i = 8'd5; ld_epn_i = epn; ld_attr_i = 6'h15; ld_rpn_i = rpn;
        ld_rpnx_i = rpnx;
        @(negedge clk);
        ld_i = 0;
    endtask

    task automatic setsc(input logic sas, input logic [7:0] spid);
        @(negedge clk);
        ld_sc_i = 1; ld_sas_i = sas; ld_spid_i = spid;
        @(negedge clk);
        ld_sc_i = 0;
    endtask

    task automatic do_wr();
        @(negedge clk);
        wr_i = 1;
        @(negedge clk);
        wr_i = 0;
        chk("R11 done after write", 64'(done_o), 64'd1);
        @(negedge clk);
        chk("R11 done one cycle", 64'(done_o), 64'd0);
    endtask

    task automatic do_srch(input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        srch_i = 1; opa_i = a; opb_i = b;
        @(negedge clk);
        srch_i = 0;
        chk("R11 done after search", 64'(done_o), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R11 watchdog act=%0d exp=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] l1_before;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        chk("R13 done", 64'(done_o), 64'd0);
        chk("R13 valid", 64'(stg_valid_o), 64'd0);
        chk("R13 l1", 64'(l1_valid_o), 64'd0);
        chk("R13 epn", 64'(stg_epn_o), 64'd0);
        chk("R13 tsel", 64'(stg_tsel_o), 64'd0);
        do_srch(64'h0, 64'h0);
        chk("R13 arrays empty", 64'(stg_valid_o), 64'd0);

        setsc(1'b0, 8'd5);
        for (int i = 0; i < 4; i++) begin
            string t;
            t = (VECS[i].tsel == 2'b01) ? "R1" : "R2";
            load(VECS[i].tsel, VECS[i].esel, VECS[i].epn, VECS[i].rpn, VECS[i].rpnx);
            do_wr();
            do_srch({VECS[i].epn, 12'h000}, 64'(i) * 64'h155);
            chk({t, " R7 hit"}, 64'(stg_valid_o), 64'd1);
            chk({t, " tsel"}, 64'(stg_tsel_o), 64'(VECS[i].tsel));
            chk({t, " esel"}, 64'(stg_esel_o), 64'(VECS[i].esel));
            chk("R7 rpn", 64'(stg_rpn_o), 64'(VECS[i].rpn));
            chk("R7 attr", 64'(stg_attr_o), 64'h15);
            chk("R3 rpnx", 64'(stg_rpnx_o), 64'(VECS[i].rpnx));
        end
        chk("R12 four fills", 64'(l1_valid_o), 64'hF);

        // R4: earlier entry intact after later writes (slot 0 refilled)
        do_srch({VECS[0].epn, 12'h000}, 64'h10);
        chk("R4 v0 hit", 64'(stg_valid_o), 64'd1);
        chk("R4 v0 rpn", 64'(stg_rpn_o), 64'(VECS[0].rpn));
        chk("R2 set1 way1 kept", 64'(VECS[3].tsel), 64'd0);

        // R8 miss on process ID
        setsc(1'b1, 8'd6);
        do_srch({VECS[0].epn, 12'h000}, 64'h0);
        chk("R8 valid", 64'(stg_valid_o), 64'd0);
        chk("R8 ts", 64'(stg_ts_o), 64'd1);
        chk("R8 tid", 64'(stg_tid_o), 64'd6);
        chk("R8 epn", 64'(stg_epn_o), 64'(VECS[0].epn));
        chk("R8 rpn kept", 64'(stg_rpn_o), 64'(VECS[0].rpn));
        chk("R12 miss no fill", 64'(l1_valid_o), 64'hF);
        setsc(1'b0, 8'd5);

        // R6 address sum with carry out of bit 63; fills slot 1 with entry 15
        do_srch(64'hFFFF_FFFF_FFFF_FFFF, {VECS[1].epn, 12'h001});
        chk("R6 hit", 64'(stg_valid_o), 64'd1);
        chk("R6 esel", 64'(stg_esel_o), 64'd15);

        // R5 victim: entry 15 overwritten, only slot 1 pointed at it
        load(2'b01, 4'd15, 52'h00888, 24'h000001, 4'h1);
        do_wr();
        chk("R5 fa victim", 64'(l1_valid_o), 64'hD);
        // R5 non-victim: set 2 way 1, same way number as a live set 1 entry
        load(2'b00, 4'd1, 52'h00502, 24'h000002, 4'h2);
        do_wr();
        chk("R5 non victim", 64'(l1_valid_o), 64'hD);
        // R5 victim in set-assoc array: set 1 way 0 (slot 2)
        load(2'b00, 4'd0, 52'h00401, 24'h000003, 4'h3);
        do_wr();
        chk("R5 sa victim", 64'(l1_valid_o), 64'h9);
        do_srch({VECS[3].epn, 12'h000}, 64'h0);
        chk("R4 way1 intact", 64'(stg_rpn_o), 64'(VECS[3].rpn));
        chk("R2 way1 esel", 64'(stg_esel_o), 64'd1);

        // R9 both arrays hit
        load(2'b00, 4'd0, 52'h00905, 24'h111111, 4'h4);
        do_wr();
        load(2'b01, 4'd9, 52'h00905, 24'h222222, 4'h6);
        do_wr();
        do_srch({52'h00905, 12'h000}, 64'h0);
        chk("R9 tsel", 64'(stg_tsel_o), 64'd1);
        chk("R9 esel", 64'(stg_esel_o), 64'd9);
        chk("R9 rpn", 64'(stg_rpn_o), 64'h222222);

        // R10 array select 10 ignored
        load(2'b10, 4'd3, 52'h0BEEF, 24'h333333, 4'h7);
        l1_before = l1_valid_o;
        do_wr();
        chk("R10 l1 unchanged", 64'(l1_valid_o), 64'(l1_before));
        do_srch({52'h0BEEF, 12'h000}, 64'h0);
        chk("R10 no entry", 64'(stg_valid_o), 64'd0);
        do_srch({VECS[0].epn, 12'h000}, 64'h0);
        chk("R10 entry 3 intact", 64'(stg_rpn_o), 64'(VECS[0].rpn));

        // R11 write and search together: only the write happens
        load(2'b01, 4'd4, 52'h0CAFE, 24'h444444, 4'h8);
        @(negedge clk);
        wr_i = 1; srch_i = 1; opa_i = {52'h0CAFE, 12'h000}; opb_i = 0;
        @(negedge clk);
        wr_i = 0; srch_i = 0;
        chk("R11 combined done", 64'(done_o), 64'd1);
        chk("R11 staging not searched", 64'(stg_tsel_o), 64'd1);
        do_srch({52'h0CAFE, 12'h000}, 64'h0);
        chk("R11 write taken", 64'(stg_rpn_o), 64'h444444);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule